// File: doc/BRIEF.md
# PHY-Side Status Handshake Controller

This block is the control logic on the PHY side of a one-lane MAC/PHY parallel interface. It does not carry data. It sequences the PHY out of reset, runs the receiver-detection handshake and manages the beacon signals. It reports all of this through one shared status strobe and a 3-bit receive-status code. All inputs are sampled on the rising edge of the parallel clock. That clock runs at 250 MHz with an 8-bit data path or 125 MHz with a 16-bit data path.

The status strobe serves three purposes. It stays high from reset until the PLL wait has elapsed and the lock indication is present, so a falling strobe means "ready". After that it pulses for one cycle when a receiver detection completes, and the result code appears with the pulse. Detection is only accepted in power state P1. The MAC must hold its request until it sees the pulse, and it must drop the request before a new detection can begin. In power state P2, a low transmit-idle input enables beacon transmission. A falling receive-idle input marks a received beacon.

The analog detector, the PLL and the line-side idle detector are outside this block. Their results arrive as plain inputs.

Top module: `phy_status_ctrl`

## Requirements
- R1: While `rst_n` is low, `phy_status` is high and `rx_status` is 000b.
- R2: After `rst_n` rises, `phy_status` stays high for LOCK_CYCLES rising edges. It falls on the next rising edge at which `pll_lock` is high, and then stays low, apart from detect pulses, until the next reset.
- R3: Power state encoding: P0=00, P0s=01, P1=10, P2=11. A detect request is accepted only when the block is ready and `pwr_state` is P1. A request in any other state produces no status pulse and leaves `rx_status` at 000b.
- R4: A detection completes DET_CYCLES rising edges after the edge that accepted the request. `phy_status` is then high for exactly one cycle, and `rx_status` carries the result in that same cycle. Outside such pulses, once the block is ready, `rx_status` is 000b.
- R5: The result code is 011b when `far_present` is high at completion and 000b when it is low.
- R6: While the request stays high after completion, no further detection or pulse occurs. A new detection needs the request to go low and then high again.
- R7: `beacon_tx_en` is high one edge after the block is ready, `pwr_state` is P2 and `tx_idle` is low. In any other case it is low one edge later.
- R8: `beacon_seen` is high for one cycle after the edge at which `rx_idle` is sampled low, provided it was high at the previous edge and `pwr_state` is P2. In other power states a falling `rx_idle` does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel interface clock |
| rst_n | input | 1 | Active-low asynchronous reset from the MAC |
| pll_lock | input | 1 | PLL lock indication (modelled) |
| pwr_state | input | 2 | Requested power state |
| det_req | input | 1 | Receiver detection request, held until the status pulse |
| far_present | input | 1 | Far-end receiver present, from the modelled detector |
| tx_idle | input | 1 | Transmit electrical-idle request |
| rx_idle | input | 1 | Receive electrical idle (modelled) |
| phy_status | output | 1 | Shared status strobe |
| rx_status | output | 3 | Receive status code |
| beacon_tx_en | output | 1 | Beacon transmission enable |
| beacon_seen | output | 1 | One-cycle flag on a received beacon |

## Verification
The assertions assume that the MAC behaves as the handshake requires. It holds `det_req` high until the completion pulse, so every pulse follows a cycle in which the request was high. It also keeps `rx_idle` high through reset, so the edge detector does not start from a false falling edge. The stimulus obeys both rules. It raises the request only at a falling clock edge and holds it until the pulse has been observed. It then releases the request one cycle later. `rx_idle` moves only after the block is ready, and `far_present` is held constant for the whole of each detection.

// File: rtl/phy_status_pkg.sv
package phy_status_pkg;

  typedef enum logic [1:0] {
    PS_P0  = 2'b00,
    PS_P0S = 2'b01,
    PS_P1  = 2'b10,
    PS_P2  = 2'b11
  } pwr_state_e;

  typedef enum logic [1:0] {
    DET_IDLE,
    DET_SENSE,
    DET_HOLD
  } det_state_e;

  localparam logic [2:0] CODE_NONE    = 3'b000;
  localparam logic [2:0] CODE_PRESENT = 3'b011;

  // Result code reported alongside the completion pulse.
  function automatic logic [2:0] det_code(input logic present);
    return present ? CODE_PRESENT : CODE_NONE;
  endfunction

  // True once the settle counter has reached its limit.
  function automatic logic count_done(input int unsigned cnt, input int unsigned limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/psc_lock_timer.sv
module psc_lock_timer
  import phy_status_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 4175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_lock,
  output logic ready
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] settle_cnt;
  logic          ready_q;
  logic          settle_done;

  assign settle_done = count_done(int'(settle_cnt), LOCK_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      ready_q    <= 1'b0;
    end else begin
      if (!settle_done) settle_cnt <= settle_cnt + 1'b1;
      if (settle_done && pll_lock) ready_q <= 1'b1;
    end
  end

  assign ready = ready_q;

  // R2: ready is sticky until the next reset
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

  // R2: ready can only appear after the lock indication was seen
  a_r2_lock_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(pll_lock));

endmodule

// File: rtl/psc_detect_fsm.sv
module psc_detect_fsm
  import phy_status_pkg::*;
#(
  parameter int unsigned DET_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       det_req,
  input  logic [1:0] pwr_state,
  input  logic       far_present,
  output logic       done_pulse,
  output logic [2:0] code
);
  localparam int unsigned CW = $clog2(DET_CYCLES + 1);

  det_state_e    st;
  logic [CW-1:0] sense_cnt;
  logic          pulse_q;
  logic [2:0]    code_q;
  logic          start;
  logic          busy;
  logic          sense_last;

  assign start      = (st == DET_IDLE) && ready && det_req && (pwr_state == PS_P1);
  assign busy       = (st == DET_SENSE);
  assign sense_last = count_done(int'(sense_cnt) + 1, DET_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= DET_IDLE;
      sense_cnt <= '0;
      pulse_q   <= 1'b0;
      code_q    <= CODE_NONE;
    end else begin
      pulse_q <= 1'b0;
      code_q  <= CODE_NONE;
      case (st)
        DET_IDLE: begin
          if (start) begin
            st        <= DET_SENSE;
            sense_cnt <= '0;
          end
        end
        DET_SENSE: begin
          if (sense_last) begin
            pulse_q <= 1'b1;
            code_q  <= det_code(far_present);
            st      <= DET_HOLD;
          end else begin
            sense_cnt <= sense_cnt + 1'b1;
          end
        end
        DET_HOLD: begin
          if (!det_req) st <= DET_IDLE;
        end
        default: st <= DET_IDLE;
      endcase
    end
  end

  assign done_pulse = pulse_q;
  assign code       = code_q;

  // R3: a detection only starts from P1 with the block ready
  a_r3_start_in_p1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(pwr_state) == PS_P1) && $past(ready));

  // R4: completion pulse lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R4: code is quiet outside the pulse
  a_r4_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> (code == CODE_NONE));

  // R5: only the two legal result codes appear
  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (code == CODE_NONE || code == CODE_PRESENT));

  // R6: a pulse is always the answer to a request that was held
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(det_req));

endmodule

// File: rtl/psc_beacon.sv
module psc_beacon
  import phy_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic [1:0] pwr_state,
  input  logic       tx_idle,
  input  logic       rx_idle,
  output logic       tx_en,
  output logic       seen
);
  logic rx_idle_q;
  logic tx_en_q;
  logic seen_q;
  logic in_p2;

  assign in_p2 = (pwr_state == PS_P2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_idle_q <= 1'b1;
      tx_en_q   <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      rx_idle_q <= rx_idle;
      tx_en_q   <= ready && in_p2 && !tx_idle;
      seen_q    <= in_p2 && rx_idle_q && !rx_idle;
    end
  end

  assign tx_en = tx_en_q;
  assign seen  = seen_q;

  // R7: beacon only sent when P2 was requested
  a_r7_tx_p2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> ($past(pwr_state) == PS_P2) && !$past(tx_idle));

  // R8: beacon flag follows a sampled low receive-idle
  a_r8_seen_low: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> !$past(rx_idle));

  // R8: beacon flag is a single-cycle event
  a_r8_seen_single: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> !seen);

endmodule

// File: rtl/phy_status_ctrl.sv
module phy_status_ctrl
  import phy_status_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 4175,
  parameter int unsigned DET_CYCLES  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pll_lock,
  input  logic [1:0] pwr_state,
  input  logic       det_req,
  input  logic       far_present,
  input  logic       tx_idle,
  input  logic       rx_idle,
  output logic       phy_status,
  output logic [2:0] rx_status,
  output logic       beacon_tx_en,
  output logic       beacon_seen
);
  logic       ready;
  logic       det_done;
  logic [2:0] det_result;

  psc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .pll_lock (pll_lock),
    .ready    (ready)
  );

  psc_detect_fsm #(.DET_CYCLES(DET_CYCLES)) u_det (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .det_req     (det_req),
    .pwr_state   (pwr_state),
    .far_present (far_present),
    .done_pulse  (det_done),
    .code        (det_result)
  );

  psc_beacon u_bcn (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .pwr_state (pwr_state),
    .tx_idle   (tx_idle),
    .rx_idle   (rx_idle),
    .tx_en     (beacon_tx_en),
    .seen      (beacon_seen)
  );

  assign phy_status = !ready || det_done;
  assign rx_status  = det_result;

  // R1: strobe is high whenever reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_status_in_reset: assert (phy_status && rx_status == CODE_NONE);
    end
  end

  // R2: the strobe never returns high after ready except for a detect pulse
  a_r2_status_source: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_status && !$past(phy_status)) |-> det_done);

endmodule

// File: tb/test_phy_status_ctrl.sv
module test_phy_status_ctrl;
  localparam int unsigned LOCK = 20;
  localparam int unsigned DETC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_lock = 1'b1;
  logic [1:0] pwr_state = 2'b10;
  logic       det_req = 1'b0;
  logic       far_present = 1'b0;
  logic       tx_idle = 1'b1;
  logic       rx_idle = 1'b1;
  logic       phy_status;
  logic [2:0] rx_status;
  logic       beacon_tx_en;
  logic       beacon_seen;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned n_pulse = 0;
  bit          mon_en = 1'b0;
  bit          prev_stat = 1'b0;
  bit          finished = 1'b0;
  logic [2:0]  exp_q[$];

  always #2.5 clk = ~clk;

  phy_status_ctrl #(.LOCK_CYCLES(LOCK), .DET_CYCLES(DETC)) i_phy_status_ctrl (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .pwr_state(pwr_state),
    .det_req(det_req), .far_present(far_present), .tx_idle(tx_idle),
    .rx_idle(rx_idle), .phy_status(phy_status), .rx_status(rx_status),
    .beacon_tx_en(beacon_tx_en), .beacon_seen(beacon_seen)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: every strobe pulse after ready must match a queued result
  always @(negedge clk) begin
    if (mon_en) begin
      if (phy_status) begin
        check(!prev_stat, "R4 pulse width", 2, 1);
        if (!prev_stat) begin
          n_pulse++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3/R6 unexpected pulse", 1, 0);
          end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check(rx_status == e, "R5 result code", int'(rx_status), int'(e));
          end
        end
      end else begin
        check(rx_status == 3'b000, "R4 quiet code", int'(rx_status), 0);
      end
    end
    prev_stat = phy_status;
  end

  // Driver: one detection handshake, result pushed to the scoreboard
  task automatic do_detect(input bit present);
    int unsigned lat;
    lat = 0;
    @(negedge clk);
    far_present = present;
    exp_q.push_back(present ? 3'b011 : 3'b000);
    det_req = 1'b1;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (phy_status) break;
    end
    check(lat == DETC + 1, "R4 detect latency", int'(lat), int'(DETC + 1));
    @(negedge clk);
    det_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int unsigned base;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(phy_status == 1'b1, "R1 status in reset", int'(phy_status), 1);
    check(rx_status == 3'b000, "R1 code in reset", int'(rx_status), 0);
    rst_n = 1'b1;
    // R2: falls on edge LOCK+1 with lock held high
    repeat (LOCK) @(negedge clk);
    check(phy_status == 1'b1, "R2 still settling", int'(phy_status), 1);
    @(negedge clk);
    check(phy_status == 1'b0, "R2 ready", int'(phy_status), 0);
    prev_stat = 1'b0;
    mon_en = 1'b1;

    // R4/R5: detections in P1, both results
    pwr_state = 2'b10;
    do_detect(1'b1);
    do_detect(1'b0);
    do_detect(1'b1);

    // R6: hold the request after completion, no second pulse
    base = n_pulse;
    @(negedge clk);
    far_present = 1'b1;
    exp_q.push_back(3'b011);
    det_req = 1'b1;
    repeat (DETC + 40) @(negedge clk);
    check(n_pulse == base + 1, "R6 single pulse while held", int'(n_pulse - base), 1);
    det_req = 1'b0;
    @(negedge clk);
    // R6: re-raising after release starts a new detection
    do_detect(1'b0);

    // R3: requests in P0, P0s, P2 are ignored
    base = n_pulse;
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      @(negedge clk);
      pwr_state = 2'(s);
      det_req = 1'b1;
      repeat (DETC + 10) @(negedge clk);
      check(phy_status == 1'b0, "R3 no status outside P1", int'(phy_status), 0);
      det_req = 1'b0;
      @(negedge clk);
    end
    check(n_pulse == base, "R3 pulses outside P1", int'(n_pulse - base), 0);

    // R7: beacon enable
    pwr_state = 2'b11;
    tx_idle = 1'b0;
    @(negedge clk);
    check(beacon_tx_en == 1'b1, "R7 beacon in P2", int'(beacon_tx_en), 1);
    tx_idle = 1'b1;
    @(negedge clk);
    check(beacon_tx_en == 1'b0, "R7 idle stops beacon", int'(beacon_tx_en), 0);
    pwr_state = 2'b10;
    tx_idle = 1'b0;
    @(negedge clk);
    check(beacon_tx_en == 1'b0, "R7 no beacon in P1", int'(beacon_tx_en), 0);
    tx_idle = 1'b1;

    // R8: beacon reception
    pwr_state = 2'b11;
    @(negedge clk);
    rx_idle = 1'b0;
    @(negedge clk);
    check(beacon_seen == 1'b1, "R8 beacon seen", int'(beacon_seen), 1);
    @(negedge clk);
    check(beacon_seen == 1'b0, "R8 single cycle", int'(beacon_seen), 0);
    rx_idle = 1'b1;
    pwr_state = 2'b00;
    @(negedge clk);
    rx_idle = 1'b0;
    @(negedge clk);
    check(beacon_seen == 1'b0, "R8 ignored outside P2", int'(beacon_seen), 0);
    rx_idle = 1'b1;
    pwr_state = 2'b10;
    @(negedge clk);

    // R1/R2: second reset, lock arrives late
    mon_en = 1'b0;
    pll_lock = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(phy_status == 1'b1, "R1 status on reassert", int'(phy_status), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * LOCK) @(negedge clk);
    check(phy_status == 1'b1, "R2 waits for lock", int'(phy_status), 1);
    pll_lock = 1'b1;
    @(negedge clk);
    check(phy_status == 1'b0, "R2 ready after lock", int'(phy_status), 0);
    prev_stat = 1'b0;
    mon_en = 1'b1;
    do_detect(1'b1);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule